// File: doc/BRIEF.md
# Adaptive Security Primitive Controller

This block sequences a reconfigurable cryptographic engine through its life cycle. It keeps a registered view of the operating environment, made of a battery-low flag and a channel-quality reading compared against a programmable threshold. From that view it reports which engine configurations are currently allowed. The host then picks a configuration. The block checks that choice against the allowed set and drives a request/done load handshake towards the datapath. When the load completes, the engine is marked ready.

While the engine runs, the block compares the throughput the host asks for with what the loaded configuration delivers. It then reloads the slowest allowed configuration that still meets the demand. The host can end a run and either keep the engine loaded (Idle) or release it (Stop). A security alarm overrides all of this. From any state it forces a reload with a configuration index given by the alarm source.

Each configuration is a 3-bit identifier. Bits [1:0] hold log2 of the pipeline depth (1, 2, 4 or 8 stages). Bit 2 selects two key generators instead of one. The throughput of an identifier in relative units is 2^(id[1:0] + id[2]).

Top module: `sec_prim_ctrl`

## Requirements
- R1: During and right after reset, `state` is 0 (Init), `cfg_req` is 0, `cfg_id` is 0 and `ready` is 0. State codes are: Init=0, Config=1, Run=2, Idle=3, Stop=4.
- R2: The environment is "low energy" when `batt_low` is 1 or `chan_q` < `chan_thr`. This condition is registered on every clock edge. `feasible` bit i is 1 for every i when the condition is clear. When it is set, bit i is 1 only if the throughput of id i is at most LOW_TP (default 2, giving 8'h13). `feasible` follows the input one edge later.
- R3: In Init, `host_param_valid` with a `host_cfg` whose `feasible` bit is set moves the block to Config with `cfg_id` = `host_cfg`. An infeasible `host_cfg` is ignored and the block stays in Init.
- R4: `cfg_req` is 1 exactly while in Config. The block stays in Config until `cfg_done`, then enters Run on the next edge, where `ready` is 1.
- R5: In Run, the target is the feasible id with the lowest throughput that is still at least `req_tput`, with ties going to the lower id. If no feasible id meets `req_tput`, the target is the fastest feasible id. When the target differs from `cfg_id`, the block enters Config with `cfg_id` = target. Otherwise it stays in Run.
- R6: In Run, `host_done` moves the block to Idle if `host_keep` is 1 and to Stop otherwise. This takes priority over throughput adaptation.
- R7: `host_start` moves the block from Idle back to Run, and from Stop back to Init. `cfg_id` is kept in both cases.
- R8: `sec_alarm` in any state moves the block to Config with `cfg_id` = `sec_cfg`, whatever the feasible set. It takes priority over `cfg_done`, host inputs and adaptation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| batt_low | input | 1 | Battery low flag |
| chan_q | input | QW | Channel quality reading |
| chan_thr | input | QW | Programmable channel quality threshold |
| feasible | output | 8 | Allowed configuration set, one bit per id |
| host_param_valid | input | 1 | Host offers a configuration |
| host_cfg | input | 3 | Configuration chosen by the host |
| host_done | input | 1 | Host ends the current computation |
| host_keep | input | 1 | 1: keep engine (Idle), 0: release it (Stop) |
| host_start | input | 1 | Leave Idle or Stop |
| req_tput | input | TW | Required throughput in relative units |
| sec_alarm | input | 1 | Security controller forces reconfiguration |
| sec_cfg | input | 3 | Configuration imposed by the alarm |
| cfg_req | output | 1 | Load request to the datapath |
| cfg_id | output | 3 | Configuration being loaded or in use |
| cfg_done | input | 1 | Datapath finished loading |
| state | output | 3 | Current controller state code |
| ready | output | 1 | Engine loaded and running |

## Verification
Every output comes straight from a register. A change of state or `cfg_id` caused by an input therefore shows up one edge after that input is sampled. A change of `feasible` caused by the environment inputs also takes one edge. A reconfiguration caused by the environment in Run takes two edges, because the target is computed from the registered environment flag. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares all outputs against that model on every falling edge. The scenario checks are placed at these one- and two-edge points.

// File: rtl/sec_prim_ctrl.sv
module sec_prim_ctrl #(
  parameter int QW     = 8,
  parameter int TW     = 5,
  parameter int LOW_TP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          batt_low,
  input  logic [QW-1:0] chan_q,
  input  logic [QW-1:0] chan_thr,
  output logic [7:0]    feasible,
  input  logic          host_param_valid,
  input  logic [2:0]    host_cfg,
  input  logic          host_done,
  input  logic          host_keep,
  input  logic          host_start,
  input  logic [TW-1:0] req_tput,
  input  logic          sec_alarm,
  input  logic [2:0]    sec_cfg,
  output logic          cfg_req,
  output logic [2:0]    cfg_id,
  input  logic          cfg_done,
  output logic [2:0]    state,
  output logic          ready
);
  localparam int NCFG = 8;
  localparam logic [2:0] S_INIT = 3'd0, S_CFG = 3'd1, S_RUN = 3'd2,
                         S_IDLE = 3'd3, S_STOP = 3'd4;

  logic          env_low;
  logic [2:0]    st, st_n, cid, cid_n, tgt;
  logic          found;
  logic [TW-1:0] best_tp;

  function automatic logic [TW-1:0] tp_of(input logic [2:0] id);
    return TW'(1) << ({1'b0, id[1:0]} + {2'b00, id[2]});
  endfunction

  for (genvar i = 0; i < NCFG; i++) begin : g_feas
    assign feasible[i] = !env_low || (tp_of(3'(i)) <= TW'(LOW_TP));
  end

  always_comb begin
    tgt = 3'd0;
    found = 1'b0;
    best_tp = '0;
    for (int i = 0; i < NCFG; i++)
      if (feasible[i] && tp_of(3'(i)) >= req_tput && (!found || tp_of(3'(i)) < best_tp)) begin
        found = 1'b1;
        best_tp = tp_of(3'(i));
        tgt = 3'(i);
      end
    if (!found)
      for (int i = 0; i < NCFG; i++)
        if (feasible[i] && tp_of(3'(i)) > best_tp) begin
          best_tp = tp_of(3'(i));
          tgt = 3'(i);
        end
  end

  always_comb begin
    st_n = st;
    cid_n = cid;
    if (sec_alarm) begin
      st_n = S_CFG;
      cid_n = sec_cfg;
    end else begin
      case (st)
        S_INIT: if (host_param_valid && feasible[host_cfg]) begin
          st_n = S_CFG;
          cid_n = host_cfg;
        end
        S_CFG: if (cfg_done) st_n = S_RUN;
        S_RUN:
          if (host_done) st_n = host_keep ? S_IDLE : S_STOP;
          else if (tgt != cid) begin
            st_n = S_CFG;
            cid_n = tgt;
          end
        S_IDLE: if (host_start) st_n = S_RUN;
        S_STOP: if (host_start) st_n = S_INIT;
        default: st_n = S_INIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_INIT;
      cid <= 3'd0;
      env_low <= 1'b0;
    end else begin
      st <= st_n;
      cid <= cid_n;
      env_low <= batt_low || (chan_q < chan_thr);
    end
  end

  assign state   = st;
  assign cfg_id  = cid;
  assign cfg_req = (st == S_CFG);
  assign ready   = (st == S_RUN);

  a_r8_alarm_forces_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    sec_alarm |=> (state == S_CFG) && (cfg_id == $past(sec_cfg)));
  a_r4_done_enters_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CFG && cfg_done && !sec_alarm) |=> ready);
  a_r4_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CFG && !cfg_done) |=> cfg_req);
  a_r3_init_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INIT && !sec_alarm && !host_param_valid) |=> state == S_INIT);
  a_r6_end_of_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && host_done && !sec_alarm) |=> state == ($past(host_keep) ? S_IDLE : S_STOP));
  a_r5_id_moves_only_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_id) |-> state == S_CFG);
endmodule

// File: tb/sec_prim_ctrl_bench.sv
module sec_prim_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic batt_low = 1'b0;
  logic [7:0] chan_q = 8'd100, chan_thr = 8'd20;
  logic [7:0] feasible;
  logic host_param_valid = 1'b0, host_done = 1'b0, host_keep = 1'b0, host_start = 1'b0;
  logic [2:0] host_cfg = 3'd0, sec_cfg = 3'd0;
  logic [4:0] req_tput = 5'd4;
  logic sec_alarm = 1'b0, cfg_done = 1'b0;
  logic cfg_req, ready;
  logic [2:0] cfg_id, state;

  int total = 0, bad = 0, cycles = 0;
  string phase = "R1";
  int m_st = 0, m_id = 0, m_low = 0;

  sec_prim_ctrl u_sec_prim_ctrl (
    .clk(clk), .rst_n(rst_n), .batt_low(batt_low), .chan_q(chan_q), .chan_thr(chan_thr),
    .feasible(feasible), .host_param_valid(host_param_valid), .host_cfg(host_cfg),
    .host_done(host_done), .host_keep(host_keep), .host_start(host_start),
    .req_tput(req_tput), .sec_alarm(sec_alarm), .sec_cfg(sec_cfg), .cfg_req(cfg_req),
    .cfg_id(cfg_id), .cfg_done(cfg_done), .state(state), .ready(ready));

  always #5 clk = ~clk;

  function automatic int rate(int id);
    return 2 ** ((id % 4) + (id / 4));
  endfunction

  function automatic int allowed(int low, int id);
    return (low == 0 || rate(id) <= 2) ? 1 : 0;
  endfunction

  function automatic int mask(int low);
    int m = 0;
    for (int i = 0; i < 8; i++) if (allowed(low, i) != 0) m += 2 ** i;
    return m;
  endfunction

  function automatic int pick(int low, int need);
    int best = -1;
    for (int i = 0; i < 8; i++)
      if (allowed(low, i) != 0 && rate(i) >= need && (best < 0 || rate(i) < rate(best))) best = i;
    if (best < 0)
      for (int i = 0; i < 8; i++)
        if (allowed(low, i) != 0 && (best < 0 || rate(i) > rate(best))) best = i;
    return best;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_id = 0; m_low = 0;
    end else begin
      int ns = m_st, ni = m_id, t;
      if (sec_alarm) begin
        ns = 1; ni = int'(sec_cfg);
      end else if (m_st == 0) begin
        if (host_param_valid && allowed(m_low, int'(host_cfg)) != 0) begin ns = 1; ni = int'(host_cfg); end
      end else if (m_st == 1) begin
        if (cfg_done) ns = 2;
      end else if (m_st == 2) begin
        if (host_done) ns = host_keep ? 3 : 4;
        else begin
          t = pick(m_low, int'(req_tput));
          if (t != m_id) begin ns = 1; ni = t; end
        end
      end else if (m_st == 3) begin
        if (host_start) ns = 2;
      end else if (host_start) ns = 0;
      m_st = ns; m_id = ni;
      m_low = (batt_low || chan_q < chan_thr) ? 1 : 0;
    end
  end

  task automatic check(string req, int got, int exp, string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(phase, int'(state), m_st, "model state");
    check(phase, int'(cfg_id), m_id, "model cfg_id");
    check(phase, int'(cfg_req), (m_st == 1) ? 1 : 0, "model cfg_req");
    check(phase, int'(ready), (m_st == 2) ? 1 : 0, "model ready");
    check(phase, int'(feasible), mask(m_low), "model feasible");
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    step(3);
    check("R1", int'(state), 0, "reset state");
    check("R1", int'(cfg_req), 0, "reset cfg_req");
    check("R1", int'(cfg_id), 0, "reset cfg_id");
    rst_n = 1'b1;
    step(1);
    check("R1", int'(ready), 0, "ready after reset");

    phase = "R2"; chan_q = 8'd10; step(1);
    check("R2", int'(feasible), 8'h13, "low-energy set");
    chan_q = 8'd100; step(1);
    check("R2", int'(feasible), 8'hFF, "full set");
    batt_low = 1'b1; step(1);
    check("R2", int'(feasible), 8'h13, "battery low set");

    phase = "R3"; host_param_valid = 1'b1; host_cfg = 3'd7; step(1);
    check("R3", int'(state), 0, "infeasible offer ignored");
    host_param_valid = 1'b0; batt_low = 1'b0; step(1);
    host_param_valid = 1'b1; host_cfg = 3'd2; step(1);
    host_param_valid = 1'b0;
    check("R3", int'(state), 1, "feasible offer accepted");
    check("R3", int'(cfg_id), 2, "host id loaded");

    phase = "R4"; step(3);
    check("R4", int'(cfg_req), 1, "request held");
    cfg_done = 1'b1; step(1); cfg_done = 1'b0;
    check("R4", int'(ready), 1, "ready after done");

    phase = "R5"; step(3);
    check("R5", int'(state), 2, "no reload when target equals id");
    req_tput = 5'd9; step(1);
    check("R5", int'(cfg_id), 7, "faster id chosen");
    cfg_done = 1'b1; step(1); cfg_done = 1'b0;
    batt_low = 1'b1; step(2);
    check("R5", int'(cfg_id), 1, "fastest feasible under low energy");
    check("R5", int'(state), 1, "reload under low energy");
    cfg_done = 1'b1; step(1); cfg_done = 1'b0;
    req_tput = 5'd1; step(1);
    check("R5", int'(cfg_id), 0, "slower id chosen");
    cfg_done = 1'b1; step(1); cfg_done = 1'b0;

    phase = "R6"; host_done = 1'b1; host_keep = 1'b1; step(1); host_done = 1'b0;
    check("R6", int'(state), 3, "keep goes Idle");
    phase = "R7"; host_start = 1'b1; step(1); host_start = 1'b0;
    check("R7", int'(state), 2, "Idle restarts Run");
    phase = "R6"; host_done = 1'b1; host_keep = 1'b0; step(1); host_done = 1'b0;
    check("R6", int'(state), 4, "release goes Stop");
    phase = "R7"; host_start = 1'b1; step(1); host_start = 1'b0;
    check("R7", int'(state), 0, "Stop returns Init");
    check("R7", int'(cfg_id), 0, "id kept");

    phase = "R8"; sec_alarm = 1'b1; sec_cfg = 3'd6; host_param_valid = 1'b1; host_cfg = 3'd1; step(1);
    sec_alarm = 1'b0; host_param_valid = 1'b0;
    check("R8", int'(cfg_id), 6, "alarm beats host offer");
    sec_alarm = 1'b1; sec_cfg = 3'd3; cfg_done = 1'b1; step(1);
    sec_alarm = 1'b0;
    check("R8", int'(state), 1, "alarm beats cfg_done");
    check("R8", int'(cfg_id), 3, "alarm id in Config");
    step(1); cfg_done = 1'b0;
    sec_alarm = 1'b1; sec_cfg = 3'd5; host_done = 1'b1; step(1);
    sec_alarm = 1'b0; host_done = 1'b0;
    check("R8", int'(cfg_id), 5, "alarm beats host_done in Run");
    cfg_done = 1'b1; step(1); cfg_done = 1'b0; step(1);
    cfg_done = 1'b1; step(1); cfg_done = 1'b0;
    host_done = 1'b1; host_keep = 1'b1; step(1); host_done = 1'b0;
    sec_alarm = 1'b1; sec_cfg = 3'd2; step(1); sec_alarm = 1'b0;
    check("R8", int'(cfg_id), 2, "alarm from Idle");
    step(4);
    finish_run();
  end
endmodule